// File: doc/BRIEF.md
# Physical Register Renamer with Branch Checkpoints

This block renames one instruction per cycle for a core whose temporaries and committed values live in one shared physical register file. For each instruction offered at decode it gives the physical registers holding both source operands. It also gives the physical register the destination is currently mapped to, which travels with the instruction so it can be released later. A fresh physical register is then taken from a circular free list and written into the speculative map. No register data passes through the block.

Retirement is reported in program order. Each retiring writer updates a second, committed map and returns its recorded earlier mapping to the tail of the free list. A branch being renamed saves the speculative map and the allocation pointer into a checkpoint slot. A misprediction copies that slot back, which also drops every checkpoint younger than the branch. An exception flush resets the speculative map to the committed map and rewinds allocation to the committed position. Architectural register 0 is hard-wired to physical register 0.

Top module: `rn_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The source outputs always show the speculative mapping of the requested registers, and architectural register 0 always reads as physical register 0.
- R2: A renamed writer of a nonzero register reports its destination's current mapping as the previous register and the head of the free list as its new register. A rename with the write flag clear or a destination of 0 reports 0 for both and allocates nothing.
- R3: After reset the free list hands out physical registers from ARCH_REGS upward in ascending order.
- R4: Each commit of a writer of a nonzero register appends its previous register to the free-list tail, and that register is handed out again once allocation reaches it.
- R5: A release by commit and an allocation by rename in the same cycle both take effect, and no free-list entry is lost.
- R6: With the free list empty, a writer of a nonzero register is refused (ready low), while an instruction that allocates nothing is accepted.
- R7: A renamed branch takes the lowest-numbered free checkpoint slot, reported on the checkpoint id. A misprediction on that id restores the speculative map and the allocation point saved after the branch's own rename.
- R8: A misprediction also frees the checkpoint slots of all younger branches, and a correctly predicted resolve frees only its own slot.
- R9: With every checkpoint slot busy, a branch is refused while a non-branch is still accepted.
- R10: An exception flush makes the speculative map equal to the committed map, including a commit in the same cycle, and rewinds allocation to the committed position.
- R11: No rename is accepted in a cycle that carries a flush or a misprediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Instruction offered for renaming |
| ren_src_a | input | AW | First source architectural register |
| ren_src_b | input | AW | Second source architectural register |
| ren_dst | input | AW | Destination architectural register |
| ren_dst_we | input | 1 | Instruction writes its destination |
| ren_branch | input | 1 | Instruction is a predicted branch |
| ren_ready | output | 1 | Rename accepted this cycle when valid |
| ren_phys_a | output | PW | Physical register of first source |
| ren_phys_b | output | PW | Physical register of second source |
| ren_phys_dst | output | PW | Newly allocated destination register |
| ren_phys_prev | output | PW | Previous mapping of the destination |
| ren_ckpt_id | output | SW | Checkpoint slot given to a branch |
| cmt_valid | input | 1 | Oldest instruction retires |
| cmt_dst_we | input | 1 | Retiring instruction wrote a register |
| cmt_dst | input | AW | Retiring destination register |
| cmt_phys_dst | input | PW | Physical register it was given |
| cmt_phys_prev | input | PW | Previous mapping to release |
| br_valid | input | 1 | A branch resolves |
| br_mispredict | input | 1 | The resolving branch was mispredicted |
| br_ckpt_id | input | SW | Checkpoint slot of the resolving branch |
| exc_flush | input | 1 | Exception: discard speculative state |

## Verification
The hardest state to reach is a misprediction that must discard younger checkpoints while an older slot has been freed and reused. That is the case where age tracking can go wrong. The stimulus fills both slots, resolves the older one correctly, allocates it again to a younger branch, and then mispredicts the remaining older branch to show that both slots become free. The free list is also driven through a wrap, an empty state, and a cycle where release and allocation coincide with one entry left.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int unsigned ARCH_REGS  = 8;
    localparam int unsigned PHYS_REGS  = 16;
    localparam int unsigned SNAP_SLOTS = 2;
    localparam int unsigned AW = $clog2(ARCH_REGS);
    localparam int unsigned PW = $clog2(PHYS_REGS);
    localparam int unsigned SW = (SNAP_SLOTS > 1) ? $clog2(SNAP_SLOTS) : 1;
    localparam int unsigned INIT_FREE = PHYS_REGS - ARCH_REGS;

    typedef logic [AW-1:0] areg_t;
    typedef logic [PW-1:0] preg_t;
    typedef logic [SW-1:0] snap_t;
    typedef logic [PW:0]   fptr_t;
    typedef preg_t [ARCH_REGS-1:0] map_t;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list
    import rn_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  alloc_i,
    input  logic  commit_i,
    input  preg_t commit_prev_i,
    input  logic  restore_i,
    input  fptr_t restore_head_i,
    input  logic  flush_i,
    output preg_t head_reg_o,
    output fptr_t head_ptr_o,
    output logic  empty_o
);
    typedef struct packed {
        preg_t [PHYS_REGS-1:0] slot;
        fptr_t                 head;
        fptr_t                 tail;
        fptr_t                 cmt_head;
    } fl_state_t;

    fl_state_t st_q, st_d;

    function automatic fl_state_t fl_reset();
        fl_state_t r;
        r = '0;
        for (int i = 0; i < int'(INIT_FREE); i++) r.slot[i] = preg_t'(ARCH_REGS + i);
        r.tail = fptr_t'(INIT_FREE);
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            st_d.slot[st_q.tail[PW-1:0]] = commit_prev_i;
            st_d.tail     = st_q.tail + fptr_t'(1);
            st_d.cmt_head = st_q.cmt_head + fptr_t'(1);
        end
        if (flush_i)        st_d.head = st_d.cmt_head;
        else if (restore_i) st_d.head = restore_head_i;
        else if (alloc_i)   st_d.head = st_q.head + fptr_t'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= fl_reset();
        else        st_q <= st_d;
    end

    assign head_reg_o = st_q.slot[st_q.head[PW-1:0]];
    assign head_ptr_o = st_q.head;
    assign empty_o    = (st_q.head == st_q.tail);

    // R6: the renamer never pops an empty list
    a_r6_no_alloc_empty: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !empty_o);
    // R5: concurrent push and pop never overrun the storage
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fptr_t'(st_q.tail - st_q.head) <= fptr_t'(PHYS_REGS));
endmodule

// File: rtl/rn_ckpt.sv
module rn_ckpt
    import rn_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  take_i,
    input  map_t  take_map_i,
    input  fptr_t take_head_i,
    input  logic  resolve_i,
    input  logic  mispredict_i,
    input  snap_t resolve_id_i,
    input  logic  flush_i,
    output logic  avail_o,
    output snap_t take_id_o,
    output map_t  rest_map_o,
    output fptr_t rest_head_o
);
    typedef struct packed {
        map_t  [SNAP_SLOTS-1:0]                  maps;
        fptr_t [SNAP_SLOTS-1:0]                  heads;
        logic  [SNAP_SLOTS-1:0]                  busy;
        logic  [SNAP_SLOTS-1:0][SNAP_SLOTS-1:0]  older;
    } ck_state_t;

    ck_state_t st_q, st_d;
    snap_t     pick;
    logic      found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < int'(SNAP_SLOTS); i++) begin
            if (!st_q.busy[i] && !found) begin
                pick  = snap_t'(i);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (resolve_i) begin
            st_d.busy[resolve_id_i] = 1'b0;
            if (mispredict_i) begin
                for (int j = 0; j < int'(SNAP_SLOTS); j++)
                    if (st_q.older[j][resolve_id_i]) st_d.busy[j] = 1'b0;
            end
        end
        if (take_i) begin
            st_d.maps[pick]  = take_map_i;
            st_d.heads[pick] = take_head_i;
            st_d.older[pick] = st_d.busy;
            for (int j = 0; j < int'(SNAP_SLOTS); j++) st_d.older[j][pick] = 1'b0;
            st_d.busy[pick]  = 1'b1;
        end
        if (flush_i) st_d.busy = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avail_o     = found;
    assign take_id_o   = pick;
    assign rest_map_o  = st_q.maps[resolve_id_i];
    assign rest_head_o = st_q.heads[resolve_id_i];

    // R9: a branch is only renamed into a free slot
    a_r9_take_has_slot: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> avail_o);
    // R8: resolves always name a live checkpoint
    a_r8_resolve_live: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_i |-> st_q.busy[resolve_id_i]);
endmodule

// File: rtl/rn_renamer.sv
module rn_renamer
    import rn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_src_a,
    input  logic [AW-1:0] ren_src_b,
    input  logic [AW-1:0] ren_dst,
    input  logic          ren_dst_we,
    input  logic          ren_branch,
    output logic          ren_ready,
    output logic [PW-1:0] ren_phys_a,
    output logic [PW-1:0] ren_phys_b,
    output logic [PW-1:0] ren_phys_dst,
    output logic [PW-1:0] ren_phys_prev,
    output logic [SW-1:0] ren_ckpt_id,
    input  logic          cmt_valid,
    input  logic          cmt_dst_we,
    input  logic [AW-1:0] cmt_dst,
    input  logic [PW-1:0] cmt_phys_dst,
    input  logic [PW-1:0] cmt_phys_prev,
    input  logic          br_valid,
    input  logic          br_mispredict,
    input  logic [SW-1:0] br_ckpt_id,
    input  logic          exc_flush
);
    typedef struct packed {
        map_t spec;
        map_t cmt;
    } rn_state_t;

    rn_state_t st_q, st_d;

    logic  fl_empty, ck_avail;
    preg_t fl_head_reg;
    fptr_t fl_head_ptr, ck_rest_head, take_head;
    map_t  ck_rest_map, spec_after;
    snap_t ck_take_id;
    logic  need_alloc, cmt_write, mispred, fire, alloc, take;

    function automatic rn_state_t rn_reset();
        rn_state_t r;
        for (int i = 0; i < int'(ARCH_REGS); i++) begin
            r.spec[i] = preg_t'(i);
            r.cmt[i]  = preg_t'(i);
        end
        return r;
    endfunction

    always_comb begin
        need_alloc = ren_dst_we && (ren_dst != '0);
        cmt_write  = cmt_valid && cmt_dst_we && (cmt_dst != '0);
        mispred    = br_valid && br_mispredict;
        ren_ready  = !exc_flush && !mispred
                     && !(need_alloc && fl_empty)
                     && !(ren_branch && !ck_avail);
        fire  = ren_valid && ren_ready;
        alloc = fire && need_alloc;
        take  = fire && ren_branch;

        spec_after = st_q.spec;
        if (alloc) spec_after[ren_dst] = fl_head_reg;
        take_head = fl_head_ptr + (alloc ? fptr_t'(1) : fptr_t'(0));

        st_d = st_q;
        if (cmt_write) st_d.cmt[cmt_dst] = cmt_phys_dst;
        if (exc_flush)    st_d.spec = st_d.cmt;
        else if (mispred) st_d.spec = ck_rest_map;
        else              st_d.spec = spec_after;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= rn_reset();
        else        st_q <= st_d;
    end

    assign ren_phys_a    = st_q.spec[ren_src_a];
    assign ren_phys_b    = st_q.spec[ren_src_b];
    assign ren_phys_dst  = need_alloc ? fl_head_reg : '0;
    assign ren_phys_prev = need_alloc ? st_q.spec[ren_dst] : '0;
    assign ren_ckpt_id   = ck_take_id;

    rn_free_list u_free (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_i        (alloc),
        .commit_i       (cmt_write),
        .commit_prev_i  (cmt_phys_prev),
        .restore_i      (mispred),
        .restore_head_i (ck_rest_head),
        .flush_i        (exc_flush),
        .head_reg_o     (fl_head_reg),
        .head_ptr_o     (fl_head_ptr),
        .empty_o        (fl_empty)
    );

    rn_ckpt u_ckpt (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_i       (take),
        .take_map_i   (spec_after),
        .take_head_i  (take_head),
        .resolve_i    (br_valid),
        .mispredict_i (br_mispredict),
        .resolve_id_i (br_ckpt_id),
        .flush_i      (exc_flush),
        .avail_o      (ck_avail),
        .take_id_o    (ck_take_id),
        .rest_map_o   (ck_rest_map),
        .rest_head_o  (ck_rest_head)
    );

    function automatic logic is_mapped(map_t m, preg_t p);
        logic hit;
        hit = 1'b0;
        for (int i = 1; i < int'(ARCH_REGS); i++) if (m[i] == p) hit = 1'b1;
        return hit;
    endfunction

    // R2: the register handed out is not live in the speculative map
    a_r2_fresh_dst: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !is_mapped(st_q.spec, fl_head_reg));
    // R10: a flush leaves the speculative map equal to the committed one
    a_r10_flush_restores: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flush |=> (st_q.spec == st_q.cmt));
endmodule

// File: tb/rn_renamer_tb.sv
module rn_renamer_tb_top;
    import rn_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic ren_valid = 0, ren_dst_we = 0, ren_branch = 0;
    logic [AW-1:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0, cmt_dst = '0;
    logic ren_ready;
    logic [PW-1:0] ren_phys_a, ren_phys_b, ren_phys_dst, ren_phys_prev;
    logic [SW-1:0] ren_ckpt_id;
    logic cmt_valid = 0, cmt_dst_we = 0;
    logic [PW-1:0] cmt_phys_dst = '0, cmt_phys_prev = '0;
    logic br_valid = 0, br_mispredict = 0, exc_flush = 0;
    logic [SW-1:0] br_ckpt_id = '0;

    rn_renamer dut_i (.*);

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit rv; bit br; bit rdy;
        int p1; int p2; int pd; int po; int sid;
        string tag;
    } exp_t;
    exp_t sbq[$];

    typedef struct { int dst; bit we; int pd; int po; int seq; } rec_t;
    rec_t infl[$];

    int sm[ARCH_REGS], cm[ARCH_REGS], fl[PHYS_REGS];
    int hd, tl, ch, seq;
    int snm[SNAP_SLOTS][ARCH_REGS];
    int snh[SNAP_SLOTS], sseq[SNAP_SLOTS];
    bit sb[SNAP_SLOTS];

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit rv, int s1, int s2, int d, bit we, bit br,
                        bit cv, bit brv, bit mis, int bid, bit fls, string tag);
        exp_t e;
        rec_t c;
        bit need;
        int sid;
        @(posedge clk); #1;
        need = we && (d != 0);
        sid = -1;
        for (int i = 0; i < SNAP_SLOTS; i++) if (!sb[i] && sid < 0) sid = i;
        e.rv = rv; e.br = br; e.tag = tag;
        e.rdy = !fls && !(brv && mis) && !(need && hd == tl) && !(br && sid < 0);
        e.p1 = sm[s1]; e.p2 = sm[s2];
        e.pd = need ? fl[hd % PHYS_REGS] : 0;
        e.po = need ? sm[d] : 0;
        e.sid = sid;
        ren_valid = rv; ren_src_a = s1[AW-1:0]; ren_src_b = s2[AW-1:0];
        ren_dst = d[AW-1:0]; ren_dst_we = we; ren_branch = br;
        br_valid = brv; br_mispredict = mis; br_ckpt_id = bid[SW-1:0];
        exc_flush = fls;
        cmt_valid = 0; cmt_dst_we = 0;
        if (cv && infl.size() > 0) begin
            c = infl.pop_front();
            cmt_valid = 1; cmt_dst_we = c.we; cmt_dst = c.dst[AW-1:0];
            cmt_phys_dst = c.pd[PW-1:0]; cmt_phys_prev = c.po[PW-1:0];
            if (c.we) begin
                cm[c.dst] = c.pd; fl[tl % PHYS_REGS] = c.po; tl++; ch++;
            end
        end
        sbq.push_back(e);
        if (brv) begin
            if (mis) begin
                for (int i = 0; i < ARCH_REGS; i++) sm[i] = snm[bid][i];
                hd = snh[bid];
                for (int j = 0; j < SNAP_SLOTS; j++) if (sb[j] && sseq[j] > sseq[bid]) sb[j] = 0;
                while (infl.size() > 0 && infl[infl.size()-1].seq > sseq[bid]) void'(infl.pop_back());
            end
            sb[bid] = 0;
        end
        if (rv && e.rdy) begin
            seq++;
            if (need) begin sm[d] = e.pd; hd++; end
            infl.push_back('{d, need, e.pd, e.po, seq});
            if (br) begin
                for (int i = 0; i < ARCH_REGS; i++) snm[sid][i] = sm[i];
                snh[sid] = hd; sseq[sid] = seq; sb[sid] = 1;
            end
        end
        if (fls) begin
            for (int i = 0; i < ARCH_REGS; i++) sm[i] = cm[i];
            hd = ch;
            for (int j = 0; j < SNAP_SLOTS; j++) sb[j] = 0;
            infl.delete();
        end
    endtask

    task automatic ren(int s1, int s2, int d, bit we, bit br, string tag);
        step(1, s1, s2, d, we, br, 0, 0, 0, 0, 0, tag);
    endtask

    // monitor: compare outputs mid-cycle against the scoreboard
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk(e.tag, "ready", int'(ren_ready), int'(e.rdy));
            chk(e.tag, "phys_a", int'(ren_phys_a), e.p1);
            chk(e.tag, "phys_b", int'(ren_phys_b), e.p2);
            if (e.rv && e.rdy) begin
                chk(e.tag, "phys_dst", int'(ren_phys_dst), e.pd);
                chk(e.tag, "phys_prev", int'(ren_phys_prev), e.po);
                if (e.br) chk(e.tag, "ckpt_id", int'(ren_ckpt_id), e.sid);
            end
        end
    end

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < ARCH_REGS; i++) begin sm[i] = i; cm[i] = i; end
        for (int i = 0; i < PHYS_REGS; i++) fl[i] = (i < INIT_FREE) ? ARCH_REGS + i : 0;
        hd = 0; tl = INIT_FREE; ch = 0; seq = 0;
        for (int j = 0; j < SNAP_SLOTS; j++) sb[j] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        step(0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset map");
        ren(0, 0, 1, 1, 0, "R3 first alloc");
        ren(1, 2, 1, 1, 0, "R2 prev mapping");
        ren(1, 0, 0, 1, 0, "R2 zero dst");
        ren(1, 1, 3, 1, 0, "R1 renamed source");
        step(1, 4, 0, 4, 1, 0, 1, 0, 0, 0, 0, "R4 commit release");
        ren(5, 4, 5, 1, 0, "R3 ascending");
        ren(6, 0, 6, 1, 0, "R3 ascending");
        ren(7, 0, 7, 1, 0, "R3 ascending");
        ren(2, 0, 2, 1, 0, "R3 last initial");
        ren(3, 0, 3, 1, 0, "R4 reuse released");
        ren(3, 0, 3, 1, 0, "R6 empty stall");
        ren(3, 5, 4, 0, 0, "R6 non-writer accepted");
        step(0, 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R4 commit only");
        step(1, 2, 0, 2, 1, 0, 1, 0, 0, 0, 0, "R4 commit no write");
        step(1, 2, 0, 2, 1, 0, 1, 0, 0, 0, 0, "R5 alloc with release");
        ren(5, 0, 5, 1, 0, "R5 released entry kept");
        ren(6, 0, 6, 1, 0, "R6 empty again");
        step(1, 1, 3, 1, 1, 0, 1, 0, 0, 0, 1, "R11 flush blocks");
        step(1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R10 committed map");
        ren(2, 5, 1, 1, 0, "R10 alloc after flush");

        ren(1, 2, 0, 0, 1, "R7 branch slot 0");
        ren(1, 0, 1, 1, 0, "R7 speculative write");
        ren(1, 2, 0, 0, 1, "R7 branch slot 1");
        ren(2, 0, 2, 1, 0, "R7 speculative write");
        ren(1, 2, 0, 0, 1, "R9 branch refused");
        ren(1, 2, 3, 1, 0, "R9 non-branch accepted");
        step(1, 1, 2, 1, 1, 0, 0, 1, 1, 0, 0, "R11 mispredict blocks");
        ren(2, 3, 1, 1, 0, "R7 restored map");
        ren(1, 2, 0, 0, 1, "R8 younger freed");
        ren(1, 2, 0, 0, 1, "R8 second slot");
        step(1, 1, 2, 0, 0, 1, 0, 1, 0, 0, 0, "R9 full during resolve");
        ren(1, 2, 4, 1, 1, "R8 correct resolve frees");
        step(0, 4, 2, 0, 0, 0, 0, 1, 1, 1, 0, "R8 mispredict older");
        ren(4, 1, 0, 0, 1, "R8 slot reuse 0");
        ren(4, 1, 0, 0, 1, "R8 slot reuse 1");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 resolve");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, "R8 resolve");

        for (int k = 0; k < 12; k++) step(0, k % ARCH_REGS, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R4 drain");
        for (int k = 0; k < 40; k++)
            step(1, k % ARCH_REGS, (k + 3) % ARCH_REGS, 1 + k % (ARCH_REGS - 1), 1, 0,
                 (k % 2) == 1, 0, 0, 0, 0, "R5 wrap traffic");

        @(posedge clk); #1;
        ren_valid = 0; cmt_valid = 0; br_valid = 0; exc_flush = 0;
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule